// File: doc/BRIEF.md
# Dual-Bank Classifier Parameter Store

This block keeps the structure and weight words of a small neural-network classifier in on-chip RAM. The words are kept apart from the inference engine that uses them. The engine reads words through a plain address port with a fixed one-cycle latency. A host writes a new image through a separate load port, one word per clock. The engine can therefore be given a new network without rebuilding or restarting the device.

The parameter `DUAL_BANK` selects one of two variants:

- **Single-bank (`DUAL_BANK = 0`).** One RAM is shared. A multiplexer hands its address port to the host whenever a write arrives. The engine is held off (`eng_stall`) until the host marks the image complete.
- **Dual-bank (`DUAL_BANK = 1`).** There are two RAMs. The active bank feeds the engine while the host rewrites the standby bank. A host swap pulse is kept pending until the engine reports that it is idle between inferences. The read-data multiplexer then switches banks on a single clock edge, so classification never stops and no inference mixes words from two images.

In both variants the engine is stalled after reset until a first image has been written. Writes beyond the image depth are dropped and raise a sticky error flag.

Top module: `wis_store`

## Requirements
- R1: The word at `eng_addr` appears on `eng_rd_data` one clock after the address is presented. It comes from the bank that was active when the address was presented.
- R2: A host write (`host_wr_en` = 1, `host_wr_addr` < `DEPTH`) stores one word per clock. A later engine read of that address returns it.
- R3: After reset, `active_bank` = 0, `busy` = 0, `err_flag` = 0 and `eng_stall` = 1. `eng_stall` falls in the cycle after the first `host_load_done` pulse.
- R4: In single-bank mode, an in-range write raises `busy` and `eng_stall` from the next cycle. Both stay high until the cycle after `host_load_done`. A pulse given together with the last write ends the load in that same clock.
- R5: In dual-bank mode, once the first image is complete, host writes go only to the standby bank. Engine reads of the active bank keep their old contents.
- R6: In dual-bank mode, a `host_swap_req` pulse raises `busy` in the next cycle. On the first clock edge where `busy` and `eng_idle` are both 1, `active_bank` toggles (0 selects bank 0, 1 selects bank 1) and `busy` clears. `active_bank` changes at no other time.
- R7: While a swap is pending and `eng_idle` is 0, `active_bank` keeps its value, `busy` stays 1, and reads still return words of the old bank.
- R8: A host write with `host_wr_addr` >= `DEPTH` does not change any stored word. It sets `err_flag` in the next cycle. `host_err_clr` clears the flag, but a write beyond the depth in the same cycle keeps it set.
- R9: In dual-bank mode, `eng_stall` never rises again once it has fallen, including while the standby bank is being loaded.
- R10: In dual-bank mode, writes made before the first image is complete land in bank 0, which is the bank the engine then reads.
- R11: A `host_swap_req` pulse given in single-bank mode, or before the first image is complete, has no effect. `busy` stays 0 and `active_bank` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eng_addr | input | AW = clog2(DEPTH) | Engine read address |
| eng_idle | input | 1 | Engine is between inferences; a pending swap may occur |
| eng_rd_data | output | WORD_W | Parameter word, one cycle after the address |
| eng_stall | output | 1 | Engine must not start an inference |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | AW | Host write address |
| host_wr_data | input | WORD_W | Host write data |
| host_load_done | input | 1 | Pulse marking the end of an image load |
| host_swap_req | input | 1 | Pulse requesting an active/standby swap |
| host_err_clr | input | 1 | Clears the sticky error flag |
| active_bank | output | 1 | Index of the bank feeding the engine |
| busy | output | 1 | Single-bank load in progress, or swap pending |
| err_flag | output | 1 | Sticky flag for a write beyond the depth |

## Verification
The bench builds two copies of the block side by side, one per variant, both with `DEPTH` = 20 and `WORD_W` = 16. Both copies receive the same stimulus, and each is compared against its own expected values. The small depth makes a complete image only twenty writes long, so several full loads, a swap and a swap back all fit in a short run. It also leaves a 5-bit address with values 20 to 31 beyond the image, which exercises the out-of-range path. Because the stimulus is shared, the same write sequence shows the single-bank copy stalling while the dual-bank copy keeps serving its old image.

// File: rtl/wis_pkg.sv
package wis_pkg;

   // Address width for a store of the given depth (at least one bit).
   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/wis_bank.sv
// One single-port RAM bank with a registered read.
module wis_bank #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned DEPTH  = 899,
   parameter int unsigned AW     = wis_pkg::addr_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[addr] <= wr_data;
      end
      if (32'(addr) < DEPTH) begin
         rd_data <= mem[addr];
      end else begin
         rd_data <= '0;
      end
   end

endmodule

// File: rtl/wis_ctrl.sv
// Load, swap, stall and error control for the parameter store.
module wis_ctrl #(
   parameter bit DUAL_BANK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ok,
   input  logic wr_oob,
   input  logic load_done,
   input  logic swap_req,
   input  logic err_clr,
   input  logic eng_idle,
   output logic active_bank,
   output logic wr_bank,
   output logic busy,
   output logic eng_stall,
   output logic err_flag
);

   logic init_q;
   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (load_done) begin
            init_q <= 1'b1;
         end
         if (wr_oob) begin
            err_q <= 1'b1;
         end else if (err_clr) begin
            err_q <= 1'b0;
         end
      end
   end

   assign err_flag = err_q;

   if (DUAL_BANK) begin : g_dual
      logic pend_q;
      logic act_q;
      logic unused_dual;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            act_q  <= 1'b0;
         end else if (pend_q) begin
            if (eng_idle) begin
               act_q  <= ~act_q;
               pend_q <= 1'b0;
            end
         end else begin
            pend_q <= swap_req & init_q;
         end
      end

      assign active_bank = act_q;
      assign wr_bank     = init_q ? ~act_q : act_q;
      assign busy        = pend_q;
      assign eng_stall   = ~init_q;
      assign unused_dual = wr_ok;
   end else begin : g_single
      logic load_q;
      logic unused_single;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            load_q <= 1'b0;
         end else if (load_done) begin
            load_q <= 1'b0;
         end else if (wr_ok) begin
            load_q <= 1'b1;
         end
      end

      assign active_bank   = 1'b0;
      assign wr_bank       = 1'b0;
      assign busy          = load_q;
      assign eng_stall     = ~init_q | load_q;
      assign unused_single = swap_req ^ eng_idle;
   end

endmodule

// File: rtl/wis_store.sv
// Parameter store for a classifier engine: one shared bank or two hot-swapped banks.
module wis_store #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned DEPTH     = 899,
   parameter bit          DUAL_BANK = 1'b1,
   localparam int unsigned AW       = wis_pkg::addr_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     eng_addr,
   input  logic              eng_idle,
   output logic [WORD_W-1:0] eng_rd_data,
   output logic              eng_stall,
   input  logic              host_wr_en,
   input  logic [AW-1:0]     host_wr_addr,
   input  logic [WORD_W-1:0] host_wr_data,
   input  logic              host_load_done,
   input  logic              host_swap_req,
   input  logic              host_err_clr,
   output logic              active_bank,
   output logic              busy,
   output logic              err_flag
);

   localparam int unsigned NUM_BANKS = DUAL_BANK ? 2 : 1;

   if (WORD_W < 1 || DEPTH < 2) begin : g_bad_cfg
      $error("wis_store: WORD_W must be >= 1 and DEPTH >= 2");
   end

   logic wr_in_range;
   logic wr_ok;
   logic wr_oob;
   logic wr_bank;

   assign wr_in_range = 32'(host_wr_addr) < DEPTH;
   assign wr_ok       = host_wr_en & wr_in_range;
   assign wr_oob      = host_wr_en & ~wr_in_range;

   wis_ctrl #(.DUAL_BANK(DUAL_BANK)) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ok       (wr_ok),
      .wr_oob      (wr_oob),
      .load_done   (host_load_done),
      .swap_req    (host_swap_req),
      .err_clr     (host_err_clr),
      .eng_idle    (eng_idle),
      .active_bank (active_bank),
      .wr_bank     (wr_bank),
      .busy        (busy),
      .eng_stall   (eng_stall),
      .err_flag    (err_flag)
   );

   logic [WORD_W-1:0] bank_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic          we_b;
      logic [AW-1:0] addr_b;

      // Host owns the address port of the bank it is writing this cycle.
      assign we_b   = wr_ok & (wr_bank == 1'(b));
      assign addr_b = we_b ? host_wr_addr : eng_addr;

      wis_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) bank_i (
         .clk     (clk),
         .wr_en   (we_b),
         .addr    (addr_b),
         .wr_data (host_wr_data),
         .rd_data (bank_rd[b])
      );
   end

   if (DUAL_BANK) begin : g_rd_mux
      logic rd_sel_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_sel_q <= 1'b0;
         end else begin
            rd_sel_q <= active_bank;
         end
      end

      assign eng_rd_data = rd_sel_q ? bank_rd[1] : bank_rd[0];
   end else begin : g_rd_one
      assign eng_rd_data = bank_rd[0];
   end

endmodule

// File: rtl/wis_store_chk.sv
// Temporal checks for wis_store, attached by bind.
module wis_store_chk #(
   parameter int unsigned DEPTH     = 899,
   parameter bit          DUAL_BANK = 1'b1,
   localparam int unsigned AW       = wis_pkg::addr_bits(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          eng_idle,
   input logic          eng_stall,
   input logic          host_wr_en,
   input logic [AW-1:0] host_wr_addr,
   input logic          host_err_clr,
   input logic          active_bank,
   input logic          busy,
   input logic          err_flag
);

   logic oob_wr;
   assign oob_wr = host_wr_en && (32'(host_wr_addr) >= DEPTH);

   AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      oob_wr |=> err_flag); // R8
   AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      host_err_clr && !oob_wr |=> !err_flag); // R8
   AST_SWAP_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
      (DUAL_BANK != 0) && busy && !eng_idle |=> $stable(active_bank) && busy); // R7
   AST_SWAP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (DUAL_BANK != 0) && busy && eng_idle |=> (active_bank != $past(active_bank)) && !busy); // R6
   AST_BANK_MOVES_ON_SWAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_bank) |-> $past(busy) && $past(eng_idle)); // R6
   AST_LOAD_HOLDS_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
      (DUAL_BANK == 0) && busy |-> eng_stall); // R4
   AST_RUN_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (DUAL_BANK != 0) && !eng_stall |=> !eng_stall); // R9

endmodule

bind wis_store wis_store_chk #(.DEPTH(DEPTH), .DUAL_BANK(DUAL_BANK)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .eng_idle     (eng_idle),
   .eng_stall    (eng_stall),
   .host_wr_en   (host_wr_en),
   .host_wr_addr (host_wr_addr),
   .host_err_clr (host_err_clr),
   .active_bank  (active_bank),
   .busy         (busy),
   .err_flag     (err_flag)
);

// File: tb/wis_store_tb_top.sv
`timescale 1ns/1ps
module wis_store_tb_top;

   localparam int unsigned W  = 16;
   localparam int unsigned D  = 20;
   localparam int unsigned AW = wis_pkg::addr_bits(D);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] eng_addr = '0;
   logic          eng_idle = 1'b0;
   logic          host_wr_en = 1'b0;
   logic [AW-1:0] host_wr_addr = '0;
   logic [W-1:0]  host_wr_data = '0;
   logic          host_load_done = 1'b0;
   logic          host_swap_req = 1'b0;
   logic          host_err_clr = 1'b0;

   logic [W-1:0] d_rd, s_rd;
   logic d_stall, s_stall, d_busy, s_busy, d_act, s_act, d_err, s_err;

   always #2 clk = ~clk;

   wis_store #(.WORD_W(W), .DEPTH(D), .DUAL_BANK(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .eng_addr(eng_addr), .eng_idle(eng_idle),
      .eng_rd_data(d_rd), .eng_stall(d_stall), .host_wr_en(host_wr_en),
      .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
      .host_load_done(host_load_done), .host_swap_req(host_swap_req),
      .host_err_clr(host_err_clr), .active_bank(d_act), .busy(d_busy), .err_flag(d_err));

   wis_store #(.WORD_W(W), .DEPTH(D), .DUAL_BANK(1'b0)) dut_sb_i (
      .clk(clk), .rst_n(rst_n), .eng_addr(eng_addr), .eng_idle(eng_idle),
      .eng_rd_data(s_rd), .eng_stall(s_stall), .host_wr_en(host_wr_en),
      .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
      .host_load_done(host_load_done), .host_swap_req(host_swap_req),
      .host_err_clr(host_err_clr), .active_bank(s_act), .busy(s_busy), .err_flag(s_err));

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Scoreboard of expected engine reads.
   typedef struct {
      logic [W-1:0] exp_d;
      logic [W-1:0] exp_s;
      int           due;
      string        tag;
   } rd_item_t;

   rd_item_t exp_q[$];

   always @(negedge clk) begin
      if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
         rd_item_t it;
         it = exp_q.pop_front();
         chk(it.tag, "dual read", 32'(d_rd), 32'(it.exp_d));
         chk(it.tag, "single read", 32'(s_rd), 32'(it.exp_s));
      end
   end

   function automatic logic [W-1:0] img_a(input int i); return W'(16'h1000 + i); endfunction
   function automatic logic [W-1:0] img_b(input int i); return W'(16'h2000 + i); endfunction
   function automatic logic [W-1:0] img_c(input int i); return W'(16'h3000 + i); endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic rd(input int a, input logic [W-1:0] ed, input logic [W-1:0] es, input string tag);
      rd_item_t it;
      eng_addr = AW'(a);
      it.exp_d = ed;
      it.exp_s = es;
      it.due   = cyc + 1;
      it.tag   = tag;
      exp_q.push_back(it);
      step();
   endtask

   task automatic wr_set(input int a, input logic [W-1:0] d, input logic done);
      host_wr_en     = 1'b1;
      host_wr_addr   = AW'(a);
      host_wr_data   = d;
      host_load_done = done;
   endtask

   task automatic wr_clear();
      host_wr_en     = 1'b0;
      host_load_done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R3 reset state
      chk("R3", "dual active", 32'(d_act), 0);
      chk("R3", "dual stall", 32'(d_stall), 1);
      chk("R3", "dual busy", 32'(d_busy), 0);
      chk("R3", "dual err", 32'(d_err), 0);
      chk("R3", "single stall", 32'(s_stall), 1);
      chk("R3", "single busy", 32'(s_busy), 0);

      // R11: swap before first image is ignored
      host_swap_req = 1'b1; eng_idle = 1'b1;
      step();
      host_swap_req = 1'b0;
      chk("R11", "dual busy pre-init", 32'(d_busy), 0);
      step();
      chk("R11", "dual active pre-init", 32'(d_act), 0);
      eng_idle = 1'b0;

      // Image A, first load
      for (int i = 0; i < int'(D); i++) begin
         wr_set(i, img_a(i), i == int'(D) - 1);
         step();
         if (i == 0) begin
            chk("R4", "single busy in load", 32'(s_busy), 1);
            chk("R4", "single stall in load", 32'(s_stall), 1);
            chk("R3", "dual stall before done", 32'(d_stall), 1);
         end
      end
      wr_clear();
      chk("R3", "dual stall after done", 32'(d_stall), 0);
      chk("R4", "single stall after done", 32'(s_stall), 0);
      chk("R4", "single busy after done", 32'(s_busy), 0);

      rd(0, img_a(0), img_a(0), "R1");
      rd(7, img_a(7), img_a(7), "R2");
      rd(19, img_a(19), img_a(19), "R10");
      step();

      // R8 out-of-range write
      wr_set(25, 16'hFFFF, 1'b0);
      step();
      wr_clear();
      chk("R8", "dual err set", 32'(d_err), 1);
      chk("R8", "single err set", 32'(s_err), 1);
      wr_set(25, 16'hEEEE, 1'b0); host_err_clr = 1'b1;
      step();
      wr_clear();
      chk("R8", "dual err set wins", 32'(d_err), 1);
      step();
      host_err_clr = 1'b0;
      chk("R8", "dual err cleared", 32'(d_err), 0);
      chk("R8", "single err cleared", 32'(s_err), 0);
      rd(5, img_a(5), img_a(5), "R8");
      step();

      // Image B into standby (dual) / shared bank (single)
      for (int i = 0; i < int'(D); i++) begin
         wr_set(i, img_b(i), i == int'(D) - 1);
         step();
         if (i == 5) begin
            chk("R9", "dual stall during standby load", 32'(d_stall), 0);
            chk("R4", "single stall during reload", 32'(s_stall), 1);
         end
      end
      wr_clear();
      rd(3, img_a(3), img_b(3), "R5");
      step();

      // Deferred swap
      host_swap_req = 1'b1;
      step();
      host_swap_req = 1'b0;
      step();
      step();
      chk("R7", "dual busy pending", 32'(d_busy), 1);
      chk("R7", "dual active held", 32'(d_act), 0);
      chk("R11", "single busy on swap", 32'(s_busy), 0);
      chk("R11", "single active on swap", 32'(s_act), 0);
      rd(3, img_a(3), img_b(3), "R7");
      eng_idle = 1'b1;
      step();
      eng_idle = 1'b0;
      chk("R6", "dual active after swap", 32'(d_act), 1);
      chk("R6", "dual busy after swap", 32'(d_busy), 0);
      rd(3, img_b(3), img_b(3), "R6");
      rd(19, img_b(19), img_b(19), "R6");
      step();

      // Write into new standby (bank 0)
      wr_set(0, img_c(0), 1'b1);
      step();
      wr_clear();
      chk("R9", "dual stall after second reload", 32'(d_stall), 0);
      rd(0, img_b(0), img_c(0), "R5");
      rd(1, img_b(1), img_b(1), "R5");
      step();

      // Immediate swap back
      eng_idle = 1'b1; host_swap_req = 1'b1;
      step();
      host_swap_req = 1'b0;
      chk("R6", "dual busy after request", 32'(d_busy), 1);
      step();
      eng_idle = 1'b0;
      chk("R6", "dual active back", 32'(d_act), 0);
      chk("R6", "dual busy cleared", 32'(d_busy), 0);
      rd(0, img_c(0), img_c(0), "R6");
      rd(1, img_a(1), img_b(1), "R6");
      step();
      step();
      chk("R1", "scoreboard drained", 32'(exp_q.size()), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule